// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-register store of a 32-bit processor that runs in one of seven operating modes. The datapath always sees sixteen architectural registers, numbered 0 to 15, through two combinational read ports and one clocked write port. Register 15 is the program counter. Behind those sixteen names sit 31 physical 32-bit words. The mode field of the status register, together with the register number, picks which physical word each access reaches.

Registers 0 to 7 and the program counter are the same physical words in every mode. The fast-interrupt mode has its own copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have their own copies of registers 13 and 14 only, and share registers 8 to 12 with the user bank. User and system modes use one common set.

A user-bank override input sends every banked access to the user/system copies whatever the current mode is. Privileged code uses it to save or restore the user context.

Top module: `rb_regfile`

## Requirements
- R1: While reset is active, every physical register is cleared to zero. After reset, every read of any register in any mode returns 0 until that register is written.
- R2: A write takes effect on the rising clock edge when the write enable is high. Reads are combinational, so a read of the register being written in that same cycle returns the old value, and the new value appears after the edge.
- R3: With the write enable low, no register changes, whatever the write address and write data are.
- R4: Registers 0 to 7 are one physical set, shared by all mode codes.
- R5: Register 15 is one physical word, common to every mode.
- R6: Mode code 5'b10001 (fast interrupt) has private copies of registers 8 to 14. A write to any of these in that mode is not visible in any other mode, and writes made in other modes are not visible in it.
- R7: Mode codes 5'b10010 (interrupt), 5'b10011 (supervisor), 5'b10111 (abort) and 5'b11011 (undefined) each have private copies of registers 13 and 14. In these modes registers 8 to 12 are the user-bank copies.
- R8: Mode codes 5'b10000 (user) and 5'b11111 (system) share one set of registers 8 to 14.
- R9: Any mode code not listed in R6 to R8 selects the user bank.
- R10: When the override input is high, accesses to registers 8 to 14 reach the user/system copies whatever the mode is.
- R11: The two read ports are independent. Each returns the register named by its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low; clears all registers |
| modeSel | input | 5 | Current mode field from the status register |
| userBank | input | 1 | High: banked registers resolve to the user/system copies |
| rdAddrA | input | 4 | Register number for read port A |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdAddrB | input | 4 | Register number for read port B |
| rdDataB | output | 32 | Read port B data (combinational) |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 4 | Register number for the write |
| wrData | input | 32 | Write data |

## Verification
A wrong bank decode shows at the ports as a value leaking between modes. A write made in one mode then appears on a read in another mode that should have its own copy, or a shared register fails to show a value written from another mode. Because reads are combinational, such a fault appears on the first later read of the affected register, which can be as early as the cycle right after the write. A fault in write timing shows in the cycle of the write itself, because a same-cycle read then returns the new value instead of the old one. The bench keeps a model of all 31 words and compares both read ports against it every cycle, across random modes, override settings and addresses.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
package rb_pkg;
  localparam int DATA_W   = 32;
  localparam int ARCH_N   = 16;
  localparam int ADDR_W   = $clog2(ARCH_N);
  localparam int SHARED_N = 8;   // registers 0..7 are never banked
  localparam int PC_NUM   = ARCH_N - 1;
  localparam int FIQ_N    = 7;   // fast-interrupt private registers 8..14
  localparam int PAIR_N   = 2;   // private 13/14 for four other modes
  localparam int PAIR_MODES = 4;
  localparam int USER_BANK_N = 7;
  localparam int NUM_PHYS = SHARED_N + USER_BANK_N + 1 + FIQ_N + PAIR_N * PAIR_MODES;
  localparam int IDX_W    = $clog2(NUM_PHYS);

  // physical layout
  localparam int FIQ_BASE = ARCH_N;                // 16..22
  localparam int IRQ_BASE = FIQ_BASE + FIQ_N;      // 23,24
  localparam int SVC_BASE = IRQ_BASE + PAIR_N;     // 25,26
  localparam int ABT_BASE = SVC_BASE + PAIR_N;     // 27,28
  localparam int UND_BASE = ABT_BASE + PAIR_N;     // 29,30

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdxA;
    logic [IDX_W-1:0] rdIdxB;
  } rfCtl_t;
endpackage

// File: rtl/rb_ctrl.sv
`timescale 1ns/1ps
module rb_ctrl
  import rb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        modeSel,
  input  logic              userBank,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrEn,
  output rfCtl_t            ctl
);
  localparam logic [ADDR_W-1:0] FIRST_BANKED = ADDR_W'(SHARED_N);
  localparam logic [ADDR_W-1:0] LAST_BANKED  = ADDR_W'(PC_NUM - 1);
  localparam logic [ADDR_W-1:0] FIRST_PAIR   = ADDR_W'(PC_NUM - PAIR_N);

  // Map an architectural number to a physical slot for the current mode.
  function automatic logic [IDX_W-1:0] mapIdx(input logic [4:0] m,
                                              input logic ovr,
                                              input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] r;
    r = IDX_W'(a);
    if (a >= FIRST_BANKED && a <= LAST_BANKED && !ovr) begin
      case (m)
        MODE_FIQ: r = IDX_W'(FIQ_BASE + int'(a) - SHARED_N);
        MODE_IRQ: if (a >= FIRST_PAIR) r = IDX_W'(IRQ_BASE + int'(a) - int'(FIRST_PAIR));
        MODE_SVC: if (a >= FIRST_PAIR) r = IDX_W'(SVC_BASE + int'(a) - int'(FIRST_PAIR));
        MODE_ABT: if (a >= FIRST_PAIR) r = IDX_W'(ABT_BASE + int'(a) - int'(FIRST_PAIR));
        MODE_UND: if (a >= FIRST_PAIR) r = IDX_W'(UND_BASE + int'(a) - int'(FIRST_PAIR));
        default:  r = IDX_W'(a);   // user, system and unknown codes
      endcase
    end
    return r;
  endfunction

  always_comb begin
    ctl.wrEn   = wrEn;
    ctl.wrIdx  = mapIdx(modeSel, userBank, wrAddr);
    ctl.rdIdxA = mapIdx(modeSel, userBank, rdAddrA);
    ctl.rdIdxB = mapIdx(modeSel, userBank, rdAddrB);
  end

  // R4: low registers never leave the shared set
  a_r4_shared_low: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA < FIRST_BANKED) |-> (ctl.rdIdxA < IDX_W'(SHARED_N)));
  // R5: the program counter is a single slot
  a_r5_pc_common: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == ADDR_W'(PC_NUM)) |-> (ctl.rdIdxB == IDX_W'(PC_NUM)));
  // R10: override confines the write to the architectural slots
  a_r10_override_user: assert property (@(posedge clk) disable iff (!rstN)
    userBank |-> (ctl.wrIdx < IDX_W'(ARCH_N)));
  // R6: fast-interrupt banked reads land in its private range
  a_r6_fiq_private: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_FIQ && !userBank && rdAddrA >= FIRST_BANKED && rdAddrA <= LAST_BANKED)
      |-> (ctl.rdIdxA >= IDX_W'(FIQ_BASE) && ctl.rdIdxA < IDX_W'(IRQ_BASE)));
endmodule

// File: rtl/rb_store.sv
`timescale 1ns/1ps
module rb_store
  import rb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [NUM_PHYS-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        if (ctl.wrEn && ctl.wrIdx == IDX_W'(i)) regs[i] <= wrData;
      end
    end
  end

  assign rdDataA = regs[ctl.rdIdxA];
  assign rdDataB = regs[ctl.rdIdxB];

  // R2: a strobed write is present in the addressed slot one edge later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> (regs[$past(ctl.wrIdx)] == $past(wrData)));
  // R3: without a strobe the whole store holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrEn |=> $stable(regs));
endmodule

// File: rtl/rb_regfile.sv
`timescale 1ns/1ps
module rb_regfile
  import rb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        modeSel,
  input  logic              userBank,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  rfCtl_t ctl;

  rb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .userBank(userBank),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrEn(wrEn),
    .ctl(ctl)
  );

  rb_store store_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: tb/rb_regfile_tb.sv
`timescale 1ns/1ps
module rb_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  modeSel = 5'b10000;
  logic        userBank = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [31];
  logic [4:0]  modeList [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                5'b10111, 5'b11011, 5'b11111, 5'b00101};

  always #4 clk = ~clk;   // 125 MHz

  rb_regfile dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .userBank(userBank),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  // Expected physical slot: bank chosen from the requirements, then offset.
  function automatic int slotOf(input logic [4:0] m, input logic ovr, input logic [3:0] a);
    int n = int'(a);
    if (n < 8 || n == 15 || ovr) return n;
    if (m == 5'b10001) return 16 + (n - 8);
    if (n < 13) return n;
    case (m)
      5'b10010: return 23 + (n - 13);
      5'b10011: return 25 + (n - 13);
      5'b10111: return 27 + (n - 13);
      5'b11011: return 29 + (n - 13);
      default:  return n;
    endcase
  endfunction

  function automatic string tagOf(input logic [4:0] m, input logic ovr, input logic [3:0] a);
    if (a < 4'd8) return "R4";
    if (a == 4'd15) return "R5";
    if (ovr) return "R10";
    if (m == 5'b10001) return "R6";
    if (m == 5'b10000 || m == 5'b11111) return "R8";
    if (m == 5'b10010 || m == 5'b10011 || m == 5'b10111 || m == 5'b11011) return "R7";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle: drive at negedge, check reads before the edge, update model after it.
  task automatic step(input logic [4:0] m, input logic ovr, input logic we,
                      input logic [3:0] wa, input logic [31:0] wd,
                      input logic [3:0] ra, input logic [3:0] rb,
                      input string tagA, input string tagB);
    @(negedge clk);
    modeSel = m; userBank = ovr; wrEn = we; wrAddr = wa; wrData = wd;
    rdAddrA = ra; rdAddrB = rb;
    #1;
    chk(tagA, rdDataA, model[slotOf(m, ovr, ra)]);
    chk(tagB, rdDataB, model[slotOf(m, ovr, rb)]);
    @(posedge clk);
    if (we) model[slotOf(m, ovr, wa)] = wd;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 31; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: everything reads zero after reset, across modes
    for (int a = 0; a < 16; a++)
      step(modeList[a % 7], 1'b0, 1'b0, 4'd0, 32'd0, 4'(a), 4'(15 - a), "R1", "R1");

    // R2: same-cycle read sees old value, next cycle the new one
    step(5'b10000, 1'b0, 1'b1, 4'd3, 32'ha5a5_0003, 4'd3, 4'd3, "R2", "R2");
    step(5'b10000, 1'b0, 1'b0, 4'd0, 32'd0, 4'd3, 4'd0, "R2", "R11");

    // R3: write enable low with live address/data leaves storage alone
    step(5'b10011, 1'b0, 1'b0, 4'd13, 32'hdead_beef, 4'd13, 4'd4, "R3", "R3");
    step(5'b10011, 1'b0, 1'b0, 4'd0, 32'd0, 4'd13, 4'd4, "R3", "R3");

    // R7: supervisor R13 private, R8 shared with user
    step(5'b10011, 1'b0, 1'b1, 4'd13, 32'h5c5c_0013, 4'd13, 4'd8, "R7", "R7");
    step(5'b10011, 1'b0, 1'b1, 4'd8,  32'h5c5c_0008, 4'd13, 4'd8, "R7", "R7");
    step(5'b10010, 1'b0, 1'b0, 4'd0, 32'd0, 4'd13, 4'd8, "R7", "R7");
    // R6: fast-interrupt R8 private
    step(5'b10001, 1'b0, 1'b1, 4'd8, 32'hf1f1_0008, 4'd8, 4'd13, "R6", "R6");
    step(5'b10000, 1'b0, 1'b0, 4'd0, 32'd0, 4'd8, 4'd13, "R6", "R6");
    // R10: override in fast-interrupt mode reaches the user R8
    step(5'b10001, 1'b1, 1'b1, 4'd8, 32'h0bad_0008, 4'd8, 4'd14, "R10", "R10");
    step(5'b11111, 1'b0, 1'b0, 4'd0, 32'd0, 4'd8, 4'd14, "R8", "R8");
    // R9: undefined code behaves as user
    step(5'b00101, 1'b0, 1'b1, 4'd14, 32'h0909_0014, 4'd14, 4'd8, "R9", "R9");
    step(5'b10000, 1'b0, 1'b0, 4'd0, 32'd0, 4'd14, 4'd15, "R9", "R5");
    // R5: PC written in abort mode, read in user mode
    step(5'b10111, 1'b0, 1'b1, 4'd15, 32'h0000_1000, 4'd15, 4'd15, "R5", "R5");
    step(5'b10000, 1'b0, 1'b0, 4'd0, 32'd0, 4'd15, 4'd2, "R5", "R11");

    // Random mix across modes, override and addresses
    for (int n = 0; n < 3000; n++) begin
      logic [4:0]  m;
      logic        ovr;
      logic [3:0]  ra, rb, wa;
      m   = modeList[$urandom_range(0, 7)];
      ovr = ($urandom_range(0, 7) == 0);
      ra  = 4'($urandom_range(0, 15));
      rb  = 4'($urandom_range(0, 15));
      wa  = ($urandom_range(0, 1) == 1) ? ra : 4'($urandom_range(0, 15));
      step(m, ovr, 1'($urandom_range(0, 1)), wa, $urandom, ra, rb,
           tagOf(m, ovr, ra), tagOf(m, ovr, rb));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule